// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Target with SMBus Extras

This block is an I2C target that sits between a two-wire bus and a byte-wide register file owned by the surrounding logic. A fast system clock samples SCL and SDA through synchronisers and glitch filters. The block finds start, repeated-start and stop conditions, matches a 7-bit device address and moves single bytes. A write transaction loads an internal address pointer and may store one byte at that pointer. A read returns the byte at the pointer.

Two SMBus features are included. The first is a CRC-8 packet error code, which the target checks on writes and returns on reads when the master clocks a byte past the data. The second is a bus inactivity timeout, which a bit in one register of the file arms.

The low three address bits come from a strap whose three-level sense arrives already decoded. The strap value follows the pin until the second transaction that matches the device. From then on it is frozen.

Top module: `i2cs_regslave`

## Requirements
- R1: The device address is 1001 followed by three strap bits. `strap_lvl` code 00 (low) gives 000, code 01 (floating) gives 010, code 10 (high) gives 011, and code 11 is treated as floating. An address byte whose top seven bits differ is not acknowledged, and the block then ignores the bus until the next start.
- R2: Until the strap is frozen, matching uses the live `strap_lvl`. On the eighth SCL rising edge of the second address byte that matches, the current strap bits are frozen. Later changes on `strap_lvl` do not change the address.
- R3: Bytes travel MSB first in nine-pulse frames. For every byte the target accepts, `sda_oe` is 1 (SDA pulled low) from the falling edge after the eighth pulse until the falling edge after the ninth.
- R4: A write made of the address byte and one further byte only loads the pointer. `rf_we` stays low.
- R5: The second byte after a write address is written to `rf_addr` = pointer through a one-cycle `rf_we` pulse. The pointer never advances, and a fourth or later written byte is not acknowledged and writes nothing.
- R6: A read returns `rf_rdata` at the pointer. Reads leave the pointer unchanged.
- R7: When the master does not acknowledge a read byte, the target releases SDA until the next start or stop. Further clocks read 0xFF.
- R8: The CRC-8 (polynomial 0x07, MSB first) is cleared at each stop and at reset. It covers every byte of the transaction, including the address byte after a repeated start. On a read, the byte after the data is the CRC and any later byte is 0xFF. On a write, the third byte after the address is acknowledged only if it equals the CRC.
- R9: Writing the register at pointer 0x19 copies its bit 6 into the timeout enable, which is 0 after reset. When it is set and neither line changes for TMO_US microseconds outside idle, the target releases SDA and returns to idle.
- R10: `sda_oe` changes only while the filtered SCL is low, except on a timeout release.
- R11: During and after reset, `sda_oe` and `rf_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_lvl | input | 2 | Decoded strap sense: 00 low, 01 floating, 10 high |
| rf_addr | output | 8 | Register file address (the pointer) |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_wdata | output | 8 | Register write data |
| rf_rdata | input | 8 | Register file read data at `rf_addr`, combinational |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except for start and stop. Every SCL level lasts far longer than the synchroniser and filter delay. The master never issues a start while the target drives a read bit. The bench drives the lines in quarter-bit steps many system clocks long and changes SDA only in the middle of the SCL low phase. It issues repeated starts only after a write byte or a not-acknowledge, so it stays inside those assumptions. Random pointers avoid the timeout-enable register so that the timeout stays under directed control.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_HOLD
  } st_t;

  localparam logic [3:0] DEV_HI    = 4'b1001;
  localparam logic [7:0] TMO_REG   = 8'h19;
  localparam int         TMO_BIT   = 6;

  // strap sense to low address bits
  function automatic logic [2:0] strap_bits(input logic [1:0] lvl);
    logic [2:0] r;
    unique case (lvl)
      2'b00:   r = 3'b000;
      2'b10:   r = 3'b011;
      default: r = 3'b010;
    endcase
    return r;
  endfunction

  // one byte of CRC-8, polynomial x^8+x^2+x+1
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/i2cs_line_filter.sv
`timescale 1ns/1ps
module i2cs_line_filter #(
  parameter int SYNC_FF  = 2,
  parameter int FILT_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [SYNC_FF-1:0]  sync_q, sync_n;
  logic [FILT_LEN-1:0] hist_q, hist_n;
  logic                q_n;

  always_comb begin
    sync_n = {sync_q[SYNC_FF-2:0], d};
    hist_n = {hist_q[FILT_LEN-2:0], sync_q[SYNC_FF-1]};
    q_n    = q;
    if (&hist_q)       q_n = 1'b1;
    else if (~|hist_q) q_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      q      <= 1'b1;
    end else begin
      sync_q <= sync_n;
      hist_q <= hist_n;
      q      <= q_n;
    end
  end
endmodule

// File: rtl/i2cs_idle_timer.sv
`timescale 1ns/1ps
module i2cs_idle_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          exp_n;

  always_comb begin
    cnt_n = cnt_q;
    exp_n = 1'b0;
    if (!run || clr) begin
      cnt_n = '0;
    end else if (cnt_q == CW'(LIMIT - 1)) begin
      cnt_n = '0;
      exp_n = 1'b1;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      expire <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      expire <= exp_n;
    end
  end
endmodule

// File: rtl/i2cs_regslave.sv
`timescale 1ns/1ps
module i2cs_regslave
  import i2cs_pkg::*;
#(
  parameter int CLK_HZ   = 200_000_000,
  parameter int TMO_US   = 25_000,
  parameter int SYNC_FF  = 2,
  parameter int FILT_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_lvl,
  output logic [7:0] rf_addr,
  output logic       rf_we,
  output logic [7:0] rf_wdata,
  input  logic [7:0] rf_rdata
);
  localparam int TMO_CYC = (CLK_HZ / 1_000_000) * TMO_US;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // line conditioning: index 1 = SCL, 0 = SDA
  logic [1:0] raw_w, filt_w;
  assign raw_w = {scl_i, sda_i};
  for (genvar g = 0; g < 2; g++) begin : g_line
    i2cs_line_filter #(.SYNC_FF(SYNC_FF), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_s), .d(raw_w[g]), .q(filt_w[g]));
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt_w[1];
  assign sda_f = filt_w[0];

  logic scl_rise, scl_fall, start_c, stop_c, edge_any, tmo_hit;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
  assign edge_any = (scl_f ^ scl_q) | (sda_f ^ sda_q);

  // state
  st_t        st_q, st_n, aft_q, aft_n;
  logic [3:0] bit_q, bit_n;
  logic [7:0] sh_q, sh_n, tx_q, tx_n, ptr_q, ptr_n, crc_q, crc_n, wd_q, wd_n;
  logic [2:0] rxi_q, rxi_n, held_q, held_n;
  logic       ack_q, ack_n, pec_q, pec_n, ten_q, ten_n, oe_q, oe_n;
  logic       seen_q, seen_n, lat_q, lat_n, we_q, we_n;

  logic [7:0] byte_v, next_tx;
  logic [6:0] own_addr;
  assign byte_v   = {sh_q[6:0], sda_f};
  assign own_addr = {DEV_HI, lat_q ? held_q : strap_bits(strap_lvl)};
  assign next_tx  = pec_q ? crc_q : 8'hFF;

  i2cs_idle_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_s),
    .run(ten_q && (st_q != ST_IDLE)), .clr(edge_any), .expire(tmo_hit));

  always_comb begin
    st_n = st_q;   aft_n = aft_q; bit_n = bit_q; sh_n = sh_q; tx_n = tx_q;
    ptr_n = ptr_q; crc_n = crc_q; wd_n = wd_q;   rxi_n = rxi_q; held_n = held_q;
    ack_n = ack_q; pec_n = pec_q; ten_n = ten_q; oe_n = oe_q;
    seen_n = seen_q; lat_n = lat_q; we_n = 1'b0;
    if (tmo_hit || stop_c) begin
      st_n = ST_IDLE; oe_n = 1'b0; crc_n = 8'h00;
    end else if (start_c) begin
      st_n = ST_RX; bit_n = 4'd0; rxi_n = 3'd0; oe_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_n  = byte_v;
            bit_n = bit_q + 4'd1;
            if (bit_q == 4'd7) begin
              aft_n = ST_RX;
              rxi_n = (rxi_q == 3'd4) ? rxi_q : rxi_q + 3'd1;
              unique case (rxi_q)
                3'd0: begin
                  if (byte_v[7:1] == own_addr) begin
                    ack_n = 1'b1;
                    crc_n = crc8_step(crc_q, byte_v);
                    aft_n = byte_v[0] ? ST_TX : ST_RX;
                    if (!lat_q) begin
                      if (seen_q) begin
                        lat_n  = 1'b1;
                        held_n = strap_bits(strap_lvl);
                      end
                      seen_n = 1'b1;
                    end
                  end else begin
                    ack_n = 1'b0;
                    aft_n = ST_IDLE;
                  end
                end
                3'd1: begin
                  ptr_n = byte_v;
                  ack_n = 1'b1;
                  crc_n = crc8_step(crc_q, byte_v);
                end
                3'd2: begin
                  we_n  = 1'b1;
                  wd_n  = byte_v;
                  ack_n = 1'b1;
                  crc_n = crc8_step(crc_q, byte_v);
                  if (ptr_q == TMO_REG) ten_n = byte_v[TMO_BIT];
                end
                3'd3:    ack_n = (byte_v == crc_q);
                default: ack_n = 1'b0;
              endcase
            end
          end else if (scl_fall && bit_q == 4'd8) begin
            st_n = ST_RX_ACK;
            oe_n = ack_q;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            st_n  = aft_q;
            bit_n = 4'd0;
            oe_n  = 1'b0;
            if (aft_q == ST_TX) begin
              tx_n  = rf_rdata;
              crc_n = crc8_step(crc_q, rf_rdata);
              pec_n = 1'b1;
              oe_n  = ~rf_rdata[7];
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_n = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              st_n = ST_TX_ACK;
              oe_n = 1'b0;
            end else begin
              tx_n = {tx_q[6:0], tx_q[7]};
              oe_n = ~tx_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            ack_n = ~sda_f;
          end else if (scl_fall) begin
            bit_n = 4'd0;
            if (ack_q) begin
              st_n  = ST_TX;
              tx_n  = next_tx;
              pec_n = 1'b0;
              oe_n  = ~next_tx[7];
            end else begin
              st_n = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      scl_q <= 1'b1;     sda_q <= 1'b1;
      st_q  <= ST_IDLE;  aft_q <= ST_IDLE;  bit_q <= '0;
      sh_q  <= '0;  tx_q <= '0;  ptr_q <= '0;  crc_q <= '0;  wd_q <= '0;
      rxi_q <= '0;  held_q <= '0;
      ack_q <= 1'b0; pec_q <= 1'b0; ten_q <= 1'b0; oe_q <= 1'b0;
      seen_q <= 1'b0; lat_q <= 1'b0; we_q <= 1'b0;
    end else begin
      scl_q <= scl_f;    sda_q <= sda_f;
      st_q  <= st_n;     aft_q <= aft_n;    bit_q <= bit_n;
      sh_q  <= sh_n; tx_q <= tx_n; ptr_q <= ptr_n; crc_q <= crc_n; wd_q <= wd_n;
      rxi_q <= rxi_n; held_q <= held_n;
      ack_q <= ack_n; pec_q <= pec_n; ten_q <= ten_n; oe_q <= oe_n;
      seen_q <= seen_n; lat_q <= lat_n; we_q <= we_n;
    end
  end

  assign sda_oe   = oe_q;
  assign rf_addr  = ptr_q;
  assign rf_we    = we_q;
  assign rf_wdata = wd_q;
endmodule

// File: rtl/i2cs_regslave_chk.sv
`timescale 1ns/1ps
module i2cs_regslave_chk
  import i2cs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input st_t        st,
  input logic       sda_oe,
  input logic       scl_f,
  input logic       rf_we,
  input logic       strap_lat,
  input logic [2:0] strap_held,
  input logic       tmo_hit
);
  // R5: register strobe lasts a single cycle
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  // R5: a strobe only appears while a written byte is being received
  p_we_in_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (st == ST_RX));

  // R2: once frozen, the strap bits never move
  p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_lat && $past(strap_lat)) |-> $stable(strap_held));

  // R7: no drive while idle or after a master not-acknowledge
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_HOLD) |-> !sda_oe);

  // R10: SDA drive moves only while SCL is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(tmo_hit)) |-> !scl_f);

  // R9: a timeout lands in idle
  p_tmo_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (st == ST_IDLE));
endmodule

bind i2cs_regslave i2cs_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_s), .st(st_q), .sda_oe(sda_oe), .scl_f(scl_f),
  .rf_we(rf_we), .strap_lat(lat_q), .strap_held(held_q), .tmo_hit(tmo_hit));

// File: tb/test_i2cs_regslave.sv
`timescale 1ns/1ps
module test_i2cs_regslave;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_n, scl_m, sda_m;
  logic [1:0] strap;
  logic       sda_oe, rf_we;
  logic [7:0] rf_addr, rf_wdata, rf_rdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int         n_chk = 0, n_fail = 0, we_cnt = 0, viol = 0;
  logic       oe_prev = 1'b0, done = 1'b0;
  wire        sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2cs_regslave #(.TMO_US(25)) i_i2cs_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_lvl(strap), .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata));

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (rf_we) begin
      mem[rf_addr] <= rf_wdata;
      we_cnt <= we_cnt + 1;
    end
  end
  assign rf_rdata = mem[rf_addr];

  // R10 monitor at the bus pins
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) viol++;
    oe_prev = sda_oe;
  end

  function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb;
      fb = x[7] ^ d[k];
      x  = {x[6:0], 1'b0};
      if (fb) x = x ^ 8'h07;
    end
    return x;
  endfunction

  function automatic logic [6:0] dev_of(input logic [1:0] s);
    return (s == 2'b00) ? 7'h48 : (s == 2'b10) ? 7'h4B : 7'h4A;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hq; repeat (Q) @(negedge clk); endtask

  task automatic m_start;
    sda_m = 1'b1; hq; scl_m = 1'b1; hq; sda_m = 1'b0; hq; scl_m = 1'b0; hq;
  endtask

  task automatic m_stop;
    sda_m = 1'b0; hq; scl_m = 1'b1; hq; sda_m = 1'b1; hq;
  endtask

  task automatic m_wr(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hq; scl_m = 1'b1; hq; hq; scl_m = 1'b0; hq;
    end
    sda_m = 1'b1; hq; scl_m = 1'b1; hq; ack = ~sda_line; hq; scl_m = 1'b0; hq;
  endtask

  task automatic m_rd(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hq; scl_m = 1'b1; hq; b = {b[6:0], sda_line}; hq; scl_m = 1'b0; hq;
    end
    sda_m = nack; hq; scl_m = 1'b1; hq; hq; scl_m = 1'b0; hq; sda_m = 1'b1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (10) @(negedge clk);
    check("R11 sda_oe in reset", 32'(sda_oe), 32'd0);
    check("R11 rf_we in reset", 32'(rf_we), 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
  endtask

  // address, pointer, data, PEC
  task automatic write_reg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d);
    logic a0, a1, a2, a3;
    logic [7:0] c;
    int w0;
    w0 = we_cnt;
    c = crc_b(crc_b(crc_b(8'h00, {a, 1'b0}), p), d);
    m_start; m_wr({a, 1'b0}, a0); m_wr(p, a1); m_wr(d, a2); m_wr(c, a3); m_stop;
    exp_mem[p] = d;
    check("R3 write acks", 32'({a0, a1, a2}), 32'b111);
    check("R8 good PEC acked", 32'(a3), 32'd1);
    check("R5 one write strobe", 32'(we_cnt - w0), 32'd1);
  endtask

  task automatic read_reg(input logic [6:0] a, input logic [7:0] p);
    logic a0, a1, a2;
    logic [7:0] d, pc, c;
    m_start; m_wr({a, 1'b0}, a0); m_wr(p, a1);
    m_start; m_wr({a, 1'b1}, a2); m_rd(1'b0, d); m_rd(1'b1, pc); m_stop;
    c = crc_b(crc_b(crc_b(crc_b(8'h00, {a, 1'b0}), p), {a, 1'b1}), exp_mem[p]);
    check("R6 read data", 32'(d), 32'(exp_mem[p]));
    check("R8 read PEC over repeated start", 32'(pc), 32'(c));
    check("R3 read acks", 32'({a0, a1, a2}), 32'b111);
  endtask

  task automatic probe(input logic [6:0] a, output logic ack);
    m_start; m_wr({a, 1'b0}, ack); m_stop;
  endtask

  initial begin
    logic ack, a1, a2, a3;
    logic [7:0] b, b2;
    int w0;
    void'($urandom(32'd1234));
    strap = 2'b01;
    do_reset;

    // pointer-only write, then read at that pointer
    w0 = we_cnt;
    m_start; m_wr({7'h4A, 1'b0}, ack); m_wr(8'h30, a1); m_stop;
    check("R1 floating strap address acked", 32'(ack), 32'd1);
    check("R4 pointer-only write, no strobe", 32'(we_cnt - w0), 32'd0);
    m_start; m_wr({7'h4A, 1'b1}, ack); m_rd(1'b1, b); m_stop;
    check("R6 read at loaded pointer", 32'(b), 32'(exp_mem[8'h30]));

    // strap now frozen at floating
    strap = 2'b10;
    probe(7'h4B, ack);
    check("R2 new strap ignored after freeze", 32'(ack), 32'd0);
    probe(7'h4A, ack);
    check("R2 frozen address still acked", 32'(ack), 32'd1);
    probe(7'h50, ack);
    check("R1 foreign address not acked", 32'(ack), 32'd0);

    write_reg(7'h4A, 8'h05, 8'h3C);
    read_reg(7'h4A, 8'h05);

    // bad PEC, then an extra byte: no auto-increment
    w0 = we_cnt;
    m_start; m_wr({7'h4A, 1'b0}, ack); m_wr(8'h06, ack); m_wr(8'h11, a1);
    m_wr(8'hEE, a2); m_wr(8'h22, a3); m_stop;
    exp_mem[8'h06] = 8'h11;
    check("R8 bad PEC not acked", 32'(a2), 32'd0);
    check("R5 fourth byte not acked", 32'(a3), 32'd0);
    check("R5 single strobe only", 32'(we_cnt - w0), 32'd1);
    read_reg(7'h4A, 8'h07);
    read_reg(7'h4A, 8'h06);

    // read: data, PEC, then 0xFF
    m_start; m_wr({7'h4A, 1'b1}, ack); m_rd(1'b0, b); m_rd(1'b0, b2); m_rd(1'b1, b); m_stop;
    check("R8 byte after PEC is FF", 32'(b), 32'hFF);
    // not-acknowledge releases the bus
    m_start; m_wr({7'h4A, 1'b1}, ack); m_rd(1'b1, b); m_rd(1'b1, b2); m_stop;
    check("R7 data before NACK", 32'(b), 32'(exp_mem[8'h06]));
    check("R7 bus released after NACK", 32'(b2), 32'hFF);

    // random traffic
    for (int it = 0; it < 10; it++) begin
      logic [7:0] p, d;
      p = 8'($urandom_range(0, 255));
      if (p == 8'h19) p = 8'h1A;
      d = 8'($urandom);
      write_reg(7'h4A, p, d);
      read_reg(7'h4A, p);
    end

    // timeout disarmed: a stalled read keeps driving
    write_reg(7'h4A, 8'h40, 8'h00);
    m_start; m_wr({7'h4A, 1'b1}, ack);
    repeat (6000) @(negedge clk);
    check("R9 timeout off, still driving", 32'(sda_oe), 32'd1);
    m_rd(1'b1, b); m_stop;
    check("R9 stalled read data", 32'(b), 32'h00);

    // timeout armed through bit 6 of register 0x19
    write_reg(7'h4A, 8'h19, 8'h40);
    m_start; m_wr({7'h4A, 1'b1}, ack);
    @(negedge clk);
    check("R9 driving before stall", 32'(sda_oe), 32'd1);
    repeat (6000) @(negedge clk);
    check("R9 timeout released SDA", 32'(sda_oe), 32'd0);
    m_stop;
    read_reg(7'h4A, 8'h19);

    // live strap until the second match
    strap = 2'b00;
    do_reset;
    probe(7'h48, ack);
    check("R1 low strap address acked", 32'(ack), 32'd1);
    strap = 2'b10;
    probe(7'h4B, ack);
    check("R2 live strap before freeze", 32'(ack), 32'd1);
    strap = 2'b00;
    probe(7'h48, ack);
    check("R2 old strap ignored after freeze", 32'(ack), 32'd0);
    probe(7'h4B, ack);
    check("R2 frozen high strap address", 32'(ack), 32'd1);

    check("R10 no SDA change with SCL high", 32'(viol), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule